// File: doc/BRIEF.md
# Two-way set-associative cache

A small word-addressed cache placed between a processor port and a slower backing memory. Each request address is cut into three fields: the low bits pick a word inside a block, the next bits pick a set, and the remaining high bits form the tag. The tag is compared against every way of the chosen set at once. A valid way whose stored tag matches is a hit, and a read hit answers on the following cycle. Any other outcome is a miss. On a miss the processor sees a busy flag while the block is brought in from memory one word at a time.

When the cache needs a way for a new block, it takes the lowest-numbered empty way of the set. Only when every way already holds a valid block does it use the per-set least-recently-used record, which every access refreshes. A build-time parameter selects the write policy. In write-back mode, writes stay in the cache and mark the block dirty, a dirty victim is copied out before it is refilled, and a write miss allocates the block. In write-through mode, every write also goes to memory, and a write miss goes only to memory. The way count may be 1, which gives a direct-mapped cache, or 2. Set count and block size must be powers of two, with at least two of each.

Top module: `set_assoc_cache`

## Requirements
- R1: The word offset is `cpuAddr[OFF_W-1:0]`, the set index is the next `SET_W` bits, and the tag is the rest. A read whose tag matches a valid way of its set is a hit. Its word appears on `cpuRdata` with `cpuValid` high in the next cycle, and `cpuBusy` stays low.
- R2: A read miss raises `cpuBusy` in the next cycle. The cache then issues `BLOCK_WORDS` memory reads, with the requested tag and set and offsets rising from 0. After that it returns the requested word with a one-cycle `cpuValid` pulse, while `cpuBusy` is low.
- R3: A miss on a set that still has an empty way fills the lowest-numbered empty way, so no valid block is displaced while an empty way remains.
- R4: When every way of the set is valid, the victim is the least recently used way. Every access refreshes that record: read or write, hit, or allocating miss.
- R5: With 2 sets, 2 ways and one block per access, the block sequence 0,2,0,1,4,0,2,3,5,4 gives miss, miss, hit, miss, miss, hit, miss, miss, miss, miss.
- R6: In write-back mode, a write hit updates only the cache, marks the block dirty and issues no memory request. A later read returns the new word.
- R7: In write-back mode, a dirty victim is written out as `BLOCK_WORDS` memory writes before the refill reads.
- R8: In write-back mode, a write miss refills the block and then writes the word into the cache only.
- R9: In write-through mode, a write hit updates the cache and issues one memory write. `cpuBusy` stays high until `memReady` ends that write.
- R10: In write-through mode, a write miss issues one memory write and allocates nothing, so a later read of that address misses.
- R11: After reset, every way is invalid, all dirty and LRU state is clear, and `cpuBusy`, `cpuValid` and `memReq` are low.
- R12: Once `memReq` is raised, `memReq`, `memWe` and `memAddr` stay unchanged until a cycle with `memReady` high. Memory is used only while `cpuBusy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | Processor request strobe, taken when `cpuBusy` is low |
| cpuWe | input | 1 | Request is a write |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Write data |
| cpuBusy | output | 1 | Cache is servicing a miss or a memory write |
| cpuValid | output | 1 | One-cycle response pulse |
| cpuRdata | output | DATA_W | Read data, meaningful with `cpuValid` on reads |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | Memory transfer is a write |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memReady | input | 1 | Memory completes the current transfer |
| memRdata | input | DATA_W | Memory read data, taken with `memReady` |

## Verification
The bench replays the classic ten-block sequence and checks, on every access, the hit or miss the design shows at its ports against a behavioural model. A design that fills by LRU instead of the first empty way, or that skips the LRU update on hits, would evict the wrong block and turn a hit into a miss. Dirty handling is checked through the backing memory itself. A write-back design that leaked writes, dropped the dirty write-out, or wrote it out in the wrong order would leave stale or early words in memory, or the wrong count of memory reads and writes. In write-through mode, a write miss followed by a read must miss, so a design that allocates on write would answer at once.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_REPLAY,
    ST_WTHRU
  } ctlState_t;

  // strobes from the sequencer to the storage datapath
  typedef struct packed {
    logic useLatch;    // probe the held request instead of the port
    logic capture;     // hold the incoming request
    logic touch;       // refresh the LRU record of the probed set
    logic writeWord;   // write the request word into the hit way
    logic setDirty;    // mark the hit way dirty
    logic respond;     // pulse the processor response
    logic pickVictim;  // freeze the victim way and its tag
    logic fillBeat;    // store one refill word
    logic fillDone;    // mark the refilled way valid and clean
    logic selEvict;    // memory address/data from the victim
    logic selWthru;    // memory address/data from the held request
  } ctlStrobe_t;

endpackage

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SETS        = 2,
  parameter int WAYS        = 2,
  parameter int BLOCK_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic [$clog2(BLOCK_WORDS)-1:0] beat,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              probeHit,
  output logic              probeWe,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              cpuValid,
  output logic [DATA_W-1:0] cpuRdata
);

  localparam int SET_W = $clog2(SETS);
  localparam int OFF_W = $clog2(BLOCK_WORDS);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]   validQ [SETS];
  logic [WAYS-1:0]   dirtyQ [SETS];
  logic [WAY_W-1:0]  lruQ   [SETS];
  logic [TAG_W-1:0]  tagQ   [WAYS][SETS];
  logic [DATA_W-1:0] dataQ  [WAYS][SETS][BLOCK_WORDS];

  logic [ADDR_W-1:0] latAddr;
  logic              latWe;
  logic [DATA_W-1:0] latWdata;
  logic [WAY_W-1:0]  vicWayQ;
  logic [TAG_W-1:0]  vicTagQ;

  logic [ADDR_W-1:0] probeAddr;
  logic [DATA_W-1:0] probeData;
  logic [OFF_W-1:0]  pOff;
  logic [SET_W-1:0]  pSet;
  logic [TAG_W-1:0]  pTag;
  logic [WAYS-1:0]   hitVec;
  logic [WAY_W-1:0]  hitWay;
  logic [WAY_W-1:0]  vicWay;
  logic [WAY_W-1:0]  lruNext;

  assign probeAddr = strobe.useLatch ? latAddr  : cpuAddr;
  assign probeData = strobe.useLatch ? latWdata : cpuWdata;
  assign probeWe   = strobe.useLatch ? latWe    : cpuWe;
  assign pOff      = probeAddr[OFF_W-1:0];
  assign pSet      = probeAddr[OFF_W +: SET_W];
  assign pTag      = probeAddr[ADDR_W-1 -: TAG_W];

  // one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validQ[pSet][w] && (tagQ[w][pSet] == pTag);
  end
  assign probeHit = |hitVec;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitWay = WAY_W'(w);
  end

  // lowest empty way wins, otherwise the LRU way
  always_comb begin
    vicWay = lruQ[pSet];
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validQ[pSet][w]) vicWay = WAY_W'(w);
  end
  assign victimDirty = validQ[pSet][vicWay] && dirtyQ[pSet][vicWay];

  assign lruNext = (WAYS == 2) ? ~hitWay : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        dirtyQ[s] <= '0;
        lruQ[s]   <= '0;
      end
      cpuValid <= 1'b0;
    end else begin
      cpuValid <= strobe.respond;
      if (strobe.touch)    lruQ[pSet] <= lruNext;
      if (strobe.setDirty) dirtyQ[pSet][hitWay] <= 1'b1;
      if (strobe.fillDone) begin
        validQ[pSet][vicWayQ] <= 1'b1;
        dirtyQ[pSet][vicWayQ] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      latAddr  <= cpuAddr;
      latWe    <= cpuWe;
      latWdata <= cpuWdata;
    end
    if (strobe.pickVictim) begin
      vicWayQ <= vicWay;
      vicTagQ <= tagQ[vicWay][pSet];
    end
    if (strobe.fillDone)  tagQ[vicWayQ][pSet] <= pTag;
    if (strobe.fillBeat)  dataQ[vicWayQ][pSet][beat] <= memRdata;
    if (strobe.writeWord) dataQ[hitWay][pSet][pOff] <= probeData;
    if (strobe.respond)   cpuRdata <= dataQ[hitWay][pSet][pOff];
  end

  always_comb begin
    if (strobe.selEvict)      memAddr = {vicTagQ, pSet, beat};
    else if (strobe.selWthru) memAddr = latAddr;
    else                      memAddr = {pTag, pSet, beat};
  end
  assign memWdata = strobe.selEvict ? dataQ[vicWayQ][pSet][beat] : latWdata;

endmodule

// File: rtl/cache_control.sv
module cache_control
  import cache_pkg::*;
#(
  parameter int BLOCK_WORDS = 2,
  parameter bit WRITE_BACK  = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuReq,
  input  logic       probeHit,
  input  logic       probeWe,
  input  logic       victimDirty,
  input  logic       memReady,
  output ctlStrobe_t strobe,
  output logic [$clog2(BLOCK_WORDS)-1:0] beat,
  output logic       memReq,
  output logic       memWe,
  output logic       cpuBusy
);

  localparam int OFF_W = $clog2(BLOCK_WORDS);

  ctlState_t        stateQ, stateD;
  logic [OFF_W-1:0] beatQ, beatD;
  logic             lastBeat;

  assign beat     = beatQ;
  assign lastBeat = (beatQ == OFF_W'(BLOCK_WORDS - 1));
  assign cpuBusy  = (stateQ != ST_IDLE);

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    beatD  = beatQ;
    memReq = 1'b0;
    memWe  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        strobe.capture = cpuReq;
        if (cpuReq) begin
          if (probeHit) begin
            strobe.touch = 1'b1;
            if (!probeWe) begin
              strobe.respond = 1'b1;
            end else begin
              strobe.writeWord = 1'b1;
              if (WRITE_BACK) begin
                strobe.setDirty = 1'b1;
                strobe.respond  = 1'b1;
              end else begin
                stateD = ST_WTHRU;
              end
            end
          end else if (probeWe && !WRITE_BACK) begin
            stateD = ST_WTHRU;
          end else begin
            strobe.pickVictim = 1'b1;
            beatD  = '0;
            stateD = victimDirty ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        strobe.useLatch = 1'b1;
        strobe.selEvict = 1'b1;
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) begin
          beatD = lastBeat ? '0 : beatQ + 1'b1;
          if (lastBeat) stateD = ST_FILL;
        end
      end
      ST_FILL: begin
        strobe.useLatch = 1'b1;
        memReq = 1'b1;
        if (memReady) begin
          strobe.fillBeat = 1'b1;
          beatD = lastBeat ? '0 : beatQ + 1'b1;
          if (lastBeat) begin
            strobe.fillDone = 1'b1;
            stateD = ST_REPLAY;
          end
        end
      end
      ST_REPLAY: begin
        strobe.useLatch = 1'b1;
        strobe.touch    = 1'b1;
        strobe.respond  = 1'b1;
        if (probeWe) begin
          strobe.writeWord = 1'b1;
          strobe.setDirty  = WRITE_BACK;
        end
        stateD = ST_IDLE;
      end
      ST_WTHRU: begin
        strobe.useLatch = 1'b1;
        strobe.selWthru = 1'b1;
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) begin
          strobe.respond = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      beatQ  <= '0;
    end else begin
      stateQ <= stateD;
      beatQ  <= beatD;
    end
  end

endmodule

// File: rtl/set_assoc_cache.sv
module set_assoc_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SETS        = 2,
  parameter int WAYS        = 2,
  parameter int BLOCK_WORDS = 2,
  parameter bit WRITE_BACK  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuBusy,
  output logic              cpuValid,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata
);

  localparam int OFF_W = $clog2(BLOCK_WORDS);

  ctlStrobe_t       strobe;
  logic [OFF_W-1:0] beat;
  logic             probeHit;
  logic             probeWe;
  logic             victimDirty;

  cache_control #(
    .BLOCK_WORDS(BLOCK_WORDS),
    .WRITE_BACK (WRITE_BACK)
  ) u_control (
    .clk        (clk),
    .rst        (rst),
    .cpuReq     (cpuReq),
    .probeHit   (probeHit),
    .probeWe    (probeWe),
    .victimDirty(victimDirty),
    .memReady   (memReady),
    .strobe     (strobe),
    .beat       (beat),
    .memReq     (memReq),
    .memWe      (memWe),
    .cpuBusy    (cpuBusy)
  );

  cache_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SETS       (SETS),
    .WAYS       (WAYS),
    .BLOCK_WORDS(BLOCK_WORDS)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .beat       (beat),
    .cpuAddr    (cpuAddr),
    .cpuWe      (cpuWe),
    .cpuWdata   (cpuWdata),
    .memRdata   (memRdata),
    .probeHit   (probeHit),
    .probeWe    (probeWe),
    .victimDirty(victimDirty),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .cpuValid   (cpuValid),
    .cpuRdata   (cpuRdata)
  );

endmodule

// File: rtl/set_assoc_cache_checker.sv
module set_assoc_cache_checker #(
  parameter int ADDR_W     = 8,
  parameter bit WRITE_BACK = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic              cpuBusy,
  input logic              cpuValid,
  input logic              memReq,
  input logic              memWe,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              probeHit
);

  assert_read_hit_fast_R1: assert property (@(posedge clk) disable iff (rst)
    cpuReq && !cpuBusy && !cpuWe && probeHit |=> cpuValid && !cpuBusy);

  assert_miss_stalls_R2: assert property (@(posedge clk) disable iff (rst)
    cpuReq && !cpuBusy && !probeHit |=> cpuBusy);

  assert_reply_when_free_R2: assert property (@(posedge clk) disable iff (rst)
    cpuValid |-> !cpuBusy);

  assert_wb_hit_local_R6: assert property (@(posedge clk) disable iff (rst)
    WRITE_BACK && cpuReq && !cpuBusy && cpuWe && probeHit |=> !memReq && cpuValid);

  assert_wt_write_mem_R9: assert property (@(posedge clk) disable iff (rst)
    !WRITE_BACK && cpuReq && !cpuBusy && cpuWe |=> cpuBusy && memReq && memWe);

  assert_mem_hold_R12: assert property (@(posedge clk) disable iff (rst)
    memReq && !memReady |=> memReq && $stable(memWe) && $stable(memAddr));

  assert_mem_only_busy_R12: assert property (@(posedge clk) disable iff (rst)
    memReq |-> cpuBusy);

endmodule

bind set_assoc_cache set_assoc_cache_checker #(
  .ADDR_W    (ADDR_W),
  .WRITE_BACK(WRITE_BACK)
) u_checker (
  .clk     (clk),
  .rst     (rst),
  .cpuReq  (cpuReq),
  .cpuWe   (cpuWe),
  .cpuBusy (cpuBusy),
  .cpuValid(cpuValid),
  .memReq  (memReq),
  .memWe   (memWe),
  .memReady(memReady),
  .memAddr (memAddr),
  .probeHit(probeHit)
);

// File: tb/test_set_assoc_cache.sv
module memModel #(
  parameter int LAT = 2
) (
  input  logic        clk,
  input  logic        req,
  input  logic        we,
  input  logic [7:0]  addr,
  input  logic [15:0] wdata,
  output logic        ready,
  output logic [15:0] rdata
);
  logic [15:0] mem [256];
  int reads = 0, writes = 0, protoErr = 0, logCount = 0, cnt = 0;
  int logAddr [64];
  bit pending = 0;
  logic [7:0] pAddr;
  logic pWe;

  initial begin
    ready = 0;
    rdata = '0;
    for (int a = 0; a < 256; a++) mem[a] = 16'(a * 37 + 16'h1200);
  end

  always @(negedge clk) begin
    if (pending && req && (addr != pAddr || we != pWe)) protoErr++;
    if (ready) begin
      ready = 0;
    end else if (req) begin
      cnt++;
      if (cnt >= LAT) begin
        cnt = 0;
        ready = 1;
        if (logCount < 64) logAddr[logCount] = int'(addr);
        logCount++;
        if (we) begin mem[addr] = wdata; writes++; end
        else begin rdata = mem[addr]; reads++; end
      end
    end else begin
      cnt = 0;
    end
    pending = req && !ready;
    pAddr = addr;
    pWe = we;
  end
endmodule

module test_set_assoc_cache;
  localparam int SETS = 2, WAYS = 2, BW = 2;

  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic cpuReq = 0, cpuWe = 0, phase = 0;
  logic [7:0] cpuAddr = '0;
  logic [15:0] cpuWdata = '0;

  logic busyWb, validWb, memReqWb, memWeWb, readyWb;
  logic busyWt, validWt, memReqWt, memWeWt, readyWt;
  logic [15:0] rdataWb, rdataWt, mWdWb, mWdWt, mRdWb, mRdWt;
  logic [7:0] mAddrWb, mAddrWt;

  set_assoc_cache #(.WRITE_BACK(1'b1)) i_set_assoc_cache (
    .clk(clk), .rst(rst), .cpuReq(cpuReq && !phase), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuBusy(busyWb),
    .cpuValid(validWb), .cpuRdata(rdataWb), .memReq(memReqWb),
    .memWe(memWeWb), .memAddr(mAddrWb), .memWdata(mWdWb),
    .memReady(readyWb), .memRdata(mRdWb));
  memModel i_memWb (.clk(clk), .req(memReqWb), .we(memWeWb), .addr(mAddrWb),
    .wdata(mWdWb), .ready(readyWb), .rdata(mRdWb));

  set_assoc_cache #(.WRITE_BACK(1'b0)) i_set_assoc_cacheWt (
    .clk(clk), .rst(rst), .cpuReq(cpuReq && phase), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuBusy(busyWt),
    .cpuValid(validWt), .cpuRdata(rdataWt), .memReq(memReqWt),
    .memWe(memWeWt), .memAddr(mAddrWt), .memWdata(mWdWt),
    .memReady(readyWt), .memRdata(mRdWt));
  memModel i_memWt (.clk(clk), .req(memReqWt), .we(memWeWt), .addr(mAddrWt),
    .wdata(mWdWt), .ready(readyWt), .rdata(mRdWt));

  wire        busy  = phase ? busyWt  : busyWb;
  wire        valid = phase ? validWt : validWb;
  wire [15:0] rdata = phase ? rdataWt : rdataWb;

  int checks = 0, errors = 0, cycles = 0;

  // behavioural reference
  int rTag [SETS][WAYS];
  bit rValid [SETS][WAYS];
  bit rDirty [SETS][WAYS];
  int rLru [SETS];
  logic [15:0] shadow [256];
  bit modeWb;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 50000);
      summary();
    end
  end

  function automatic int memReads();  return phase ? i_memWt.reads  : i_memWb.reads;  endfunction
  function automatic int memWrites(); return phase ? i_memWt.writes : i_memWb.writes; endfunction
  function automatic logic [15:0] memAt(int a);
    return phase ? i_memWt.mem[a] : i_memWb.mem[a];
  endfunction

  task automatic modelReset(input bit wb);
    modeWb = wb;
    for (int s = 0; s < SETS; s++) begin
      rLru[s] = 0;
      for (int w = 0; w < WAYS; w++) begin rValid[s][w] = 0; rDirty[s][w] = 0; rTag[s][w] = 0; end
    end
    for (int a = 0; a < 256; a++) shadow[a] = 16'(a * 37 + 16'h1200);
  endtask

  task automatic doAcc(input bit we, input int addr, input logic [15:0] wdata,
                       input string req, output bit dutHit);
    int blk, set, tg, hw, vic, expReads, expWrites, r0, w0, cyc;
    bit expFast;
    logic [15:0] expData;
    blk = addr / BW; set = blk % SETS; tg = blk / SETS; hw = -1;
    expReads = 0; expWrites = 0; expData = shadow[addr];
    for (int w = 0; w < WAYS; w++) if (rValid[set][w] && rTag[set][w] == tg) hw = w;
    expFast = (hw >= 0) && !(we && !modeWb);
    if (hw >= 0) begin
      rLru[set] = 1 - hw;
      if (we) begin shadow[addr] = wdata; if (modeWb) rDirty[set][hw] = 1; else expWrites = 1; end
    end else if (we && !modeWb) begin
      expWrites = 1; shadow[addr] = wdata;
    end else begin
      vic = rLru[set];
      for (int w = WAYS - 1; w >= 0; w--) if (!rValid[set][w]) vic = w;
      if (rValid[set][vic] && rDirty[set][vic]) expWrites = BW;
      expReads = BW;
      rValid[set][vic] = 1; rTag[set][vic] = tg; rDirty[set][vic] = 0;
      rLru[set] = 1 - vic;
      if (we) begin shadow[addr] = wdata; rDirty[set][vic] = 1; end
    end
    r0 = memReads(); w0 = memWrites();
    cpuReq = 1; cpuWe = we; cpuAddr = 8'(addr); cpuWdata = wdata;
    @(negedge clk);
    cpuReq = 0;
    dutHit = valid && !busy;
    if (expFast) begin
      check(valid && !busy, req, $sformatf("fast reply addr %0d", addr), {valid, busy}, 2);
    end else begin
      check(busy, req, $sformatf("busy after request addr %0d", addr), busy, 1);
      cyc = 0;
      while (!valid && cyc < 500) begin @(negedge clk); cyc++; end
      check(valid && !busy, req, $sformatf("late reply addr %0d", addr), {valid, busy}, 2);
    end
    if (!we) check(rdata == expData, req, $sformatf("read data addr %0d", addr), rdata, expData);
    check(memReads() - r0 == expReads, req, $sformatf("memory reads addr %0d", addr), memReads() - r0, expReads);
    check(memWrites() - w0 == expWrites, req, $sformatf("memory writes addr %0d", addr), memWrites() - w0, expWrites);
  endtask

  initial begin
    bit h;
    int seq [10] = '{0, 4, 0, 2, 8, 0, 4, 6, 10, 8};
    bit expSeq [10] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 0};
    int l0;
    modelReset(1);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: idle after reset
    check(!busyWb && !validWb && !memReqWb, "R11", "wb idle", {busyWb, validWb, memReqWb}, 0);
    check(!busyWt && !validWt && !memReqWt, "R11", "wt idle", {busyWt, validWt, memReqWt}, 0);

    // R5: block sequence 0,2,0,1,4,0,2,3,5,4 (two words per block)
    foreach (seq[i]) begin
      doAcc(0, seq[i], 0, "R5", h);
      check(h == expSeq[i], "R5", $sformatf("hit flag step %0d", i), h, expSeq[i]);
    end
    // R1: offset 1 words of resident blocks
    doAcc(0, 9, 0, "R1", h);  check(h, "R1", "offset hit addr 9", h, 1);
    doAcc(0, 5, 0, "R1", h);  check(h, "R1", "offset hit addr 5", h, 1);
    // R2: refill order
    l0 = i_memWb.logCount;
    doAcc(0, 1, 0, "R2", h);  check(!h, "R2", "miss addr 1", h, 0);
    check(i_memWb.logAddr[l0] == 0 && i_memWb.logAddr[l0 + 1] == 1, "R2", "refill order",
          i_memWb.logAddr[l0] * 256 + i_memWb.logAddr[l0 + 1], 1);
    // R6: write hit stays local
    doAcc(1, 1, 16'hBEEF, "R6", h);  check(h, "R6", "write hit", h, 1);
    check(memAt(1) == 16'(1 * 37 + 16'h1200), "R6", "memory untouched", memAt(1), 16'(37 + 16'h1200));
    doAcc(0, 1, 0, "R6", h);
    // R4: the written block is most recent, so the miss evicts the other way
    doAcc(0, 12, 0, "R4", h);
    doAcc(0, 1, 0, "R4", h);  check(h, "R4", "recent block kept", h, 1);
    // R7: block 0 is now LRU and dirty
    doAcc(0, 12, 0, "R4", h); check(h, "R4", "read refresh", h, 1);
    doAcc(0, 16, 0, "R7", h);
    check(memAt(1) == 16'hBEEF, "R7", "dirty word written out", memAt(1), 16'hBEEF);
    check(memAt(0) == 16'h1200, "R7", "clean word written out", memAt(0), 16'h1200);
    // R8: write miss allocates
    doAcc(1, 21, 16'hCAFE, "R8", h);  check(!h, "R8", "write miss", h, 0);
    check(memAt(21) == 16'(21 * 37 + 16'h1200), "R8", "memory stale", memAt(21), 16'(21 * 37 + 16'h1200));
    doAcc(0, 21, 0, "R8", h);  check(h, "R8", "allocated block hit", h, 1);

    // write-through instance
    phase = 1;
    modelReset(0);
    @(negedge clk);
    doAcc(0, 0, 0, "R3", h);
    doAcc(0, 4, 0, "R3", h);
    doAcc(0, 0, 0, "R3", h);  check(h, "R3", "first block kept", h, 1);
    doAcc(0, 4, 0, "R3", h);  check(h, "R3", "second block kept", h, 1);
    doAcc(1, 0, 16'h1234, "R9", h);
    check(memAt(0) == 16'h1234, "R9", "memory updated", memAt(0), 16'h1234);
    doAcc(0, 0, 0, "R9", h);  check(h, "R9", "cache updated", h, 1);
    doAcc(1, 60, 16'h5678, "R10", h);
    check(memAt(60) == 16'h5678, "R10", "memory written", memAt(60), 16'h5678);
    doAcc(0, 60, 0, "R10", h); check(!h, "R10", "no allocation", h, 0);

    check(i_memWb.protoErr == 0 && i_memWt.protoErr == 0, "R12", "request held until ready",
          i_memWb.protoErr + i_memWt.protoErr, 0);
    summary();
  end
endmodule